// File: doc/BRIEF.md
# Prewitt Gradient Unit

This block computes the horizontal and vertical intensity gradient at one pixel of an image. A request presents an integer (x, y) coordinate together with a start strobe. The unit then fetches the nine pixels of the 3x3 neighbourhood itself through a simple read port, one pixel per cycle. Both gradients are built from that one pass over the neighbourhood, using unit-weight Prewitt kernels. Both signed results are returned together with a single-cycle done strobe.

The unit is a fixed-latency instruction unit. The result appears a set number of cycles after the request is accepted, however the neighbourhood falls. Neighbours that lie beyond the image edge are replaced by the nearest pixel inside the image. A busy flag marks the whole operation, and requests made while it is raised are dropped. The read port expects registered memory: the pixel addressed in one cycle is presented on the data input in the next cycle.

Top module: `gradPrewittUnit`

## Requirements
- R1: While reset is held and after it is released with no request, busy, done and memRd are 0 and both gradient outputs are 0.
- R2: A start seen at a clock edge while busy is 0 is accepted, and busy reads 1 in the following cycle.
- R3: done is high for exactly one cycle, LATENCY clock edges (default 33) after the accepting edge. busy stays high through that cycle and is 0 in the next.
- R4: start pulses and coordinate changes while busy is 1 have no effect on the running result or its timing, and no second operation follows.
- R5: Each operation issues exactly nine reads (memRd high for nine cycles). Every read coordinate lies inside the image, 0..IMG_W-1 by 0..IMG_H-1.
- R6: gradX equals the sum of the three pixels in column x+1 minus the sum of the three pixels in column x-1.
- R7: gradY equals the sum of the three pixels in row y+1 minus the sum of the three pixels in row y-1, with y growing downward.
- R8: A neighbour coordinate below 0 is read as 0, and one above the last column or row is read as that last column or row.
- R9: gradX and gradY hold their values from the done cycle until the next request is accepted.
- R10: Results are signed two's complement, PIX_W+3 bits wide (11 by default), and reach ±3·(2^PIX_W−1) (±765) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while busy is 0 |
| pixX | input | X_W (6) | Column of the centre pixel |
| pixY | input | Y_W (6) | Row of the centre pixel |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle result strobe |
| gradX | output | PIX_W+3 (11) | Signed horizontal gradient |
| gradY | output | PIX_W+3 (11) | Signed vertical gradient |
| memRd | output | 1 | Pixel read request |
| memX | output | X_W (6) | Column of the pixel being read |
| memY | output | Y_W (6) | Row of the pixel being read |
| memData | input | PIX_W (8) | Pixel returned one cycle after the read |

## Verification
The unit is driven with several images. Horizontal and vertical ramps show that each axis responds only to its own direction and that the sign is right. Step edges give the largest positive and negative results, which shows that the 11-bit range holds. A flat image must give zero on both axes. A mixed ramp, sampled at opposite corners and at the interior, shows that edge clamping mirrors correctly on all four sides. Directed runs drive start while the unit is busy and confirm that the result, the latency and the read count do not change.

// File: rtl/gradPkg.sv
package gradPkg;

  typedef struct packed {
    logic load;
    logic fetch;
    logic accum;
  } gradCtrlT;

  localparam int TAPS = 9;

endpackage

// File: rtl/gradCtrl.sv
module gradCtrl
  import gradPkg::*;
#(
  parameter int LATENCY = 33
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output gradCtrlT ctrl,
  output logic     busy,
  output logic     done
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} stateT;

  stateT            state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(LATENCY - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load  = (state == ST_IDLE) && start;
    ctrl.fetch = (state == ST_RUN) && (cnt < CNT_W'(TAPS));
    ctrl.accum = (state == ST_RUN) && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(TAPS));
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/gradDatapath.sv
module gradDatapath
  import gradPkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  parameter int X_W    = 6,
  parameter int Y_W    = 6,
  parameter int GRAD_W = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  gradCtrlT                 ctrl,
  input  logic [X_W-1:0]           pixX,
  input  logic [Y_W-1:0]           pixY,
  input  logic [PIX_W-1:0]         memData,
  output logic [X_W-1:0]           memX,
  output logic [Y_W-1:0]           memY,
  output logic signed [GRAD_W-1:0] gradX,
  output logic signed [GRAD_W-1:0] gradY
);

  logic [X_W-1:0]           baseX;
  logic [Y_W-1:0]           baseY;
  logic [3:0]               fetchTap;
  logic [3:0]               accTap;
  logic signed [GRAD_W-1:0] accX;
  logic signed [GRAD_W-1:0] accY;
  logic signed [GRAD_W-1:0] pixExt;
  int                       nx;
  int                       ny;
  int                       accCol;
  int                       accRow;

  // Neighbour address: column = tap mod 3, row = tap div 3, both offset by -1, clamped to the image.
  always_comb begin
    nx = int'(baseX) + (int'(fetchTap) % 3) - 1;
    ny = int'(baseY) + (int'(fetchTap) / 3) - 1;
    if (nx < 0) nx = 0;
    else if (nx > IMG_W - 1) nx = IMG_W - 1;
    if (ny < 0) ny = 0;
    else if (ny > IMG_H - 1) ny = IMG_H - 1;
    memX = X_W'(nx);
    memY = Y_W'(ny);
  end

  always_comb begin
    accCol = int'(accTap) % 3;
    accRow = int'(accTap) / 3;
    pixExt = $signed({{(GRAD_W - PIX_W){1'b0}}, memData});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseX    <= '0;
      baseY    <= '0;
      fetchTap <= '0;
      accTap   <= '0;
      accX     <= '0;
      accY     <= '0;
    end else if (ctrl.load) begin
      baseX    <= pixX;
      baseY    <= pixY;
      fetchTap <= '0;
      accTap   <= '0;
      accX     <= '0;
      accY     <= '0;
    end else begin
      if (ctrl.fetch) fetchTap <= fetchTap + 1'b1;
      if (ctrl.accum) begin
        accTap <= accTap + 1'b1;
        if (accCol == 2)      accX <= accX + pixExt;
        else if (accCol == 0) accX <= accX - pixExt;
        if (accRow == 2)      accY <= accY + pixExt;
        else if (accRow == 0) accY <= accY - pixExt;
      end
    end
  end

  assign gradX = accX;
  assign gradY = accY;

endmodule

// File: rtl/gradPrewittUnit.sv
module gradPrewittUnit
  import gradPkg::*;
#(
  parameter  int PIX_W   = 8,
  parameter  int IMG_W   = 64,
  parameter  int IMG_H   = 48,
  parameter  int LATENCY = 33,
  localparam int X_W     = $clog2(IMG_W),
  localparam int Y_W     = $clog2(IMG_H),
  localparam int GRAD_W  = PIX_W + 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [X_W-1:0]           pixX,
  input  logic [Y_W-1:0]           pixY,
  output logic                     busy,
  output logic                     done,
  output logic signed [GRAD_W-1:0] gradX,
  output logic signed [GRAD_W-1:0] gradY,
  output logic                     memRd,
  output logic [X_W-1:0]           memX,
  output logic [Y_W-1:0]           memY,
  input  logic [PIX_W-1:0]         memData
);

  gradCtrlT ctrl;

  gradCtrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  gradDatapath #(
    .PIX_W (PIX_W),
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .X_W   (X_W),
    .Y_W   (Y_W),
    .GRAD_W(GRAD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .pixX   (pixX),
    .pixY   (pixY),
    .memData(memData),
    .memX   (memX),
    .memY   (memY),
    .gradX  (gradX),
    .gradY  (gradY)
  );

  assign memRd = ctrl.fetch;

endmodule

// File: rtl/gradChk.sv
module gradChk #(
  parameter  int PIX_W   = 8,
  parameter  int IMG_W   = 64,
  parameter  int IMG_H   = 48,
  parameter  int LATENCY = 33,
  localparam int X_W     = $clog2(IMG_W),
  localparam int Y_W     = $clog2(IMG_H),
  localparam int GRAD_W  = PIX_W + 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic signed [GRAD_W-1:0] gradX,
  input logic signed [GRAD_W-1:0] gradY,
  input logic                     memRd,
  input logic [Y_W-1:0]           memY
);

  int latCnt;
  int rdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt <= 0;
      rdCnt  <= 0;
    end else if (start && !busy) begin
      latCnt <= 0;
      rdCnt  <= 0;
    end else begin
      if (busy)  latCnt <= latCnt + 1;
      if (memRd) rdCnt  <= rdCnt + 1;
    end
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == LATENCY));

  a_r5_nine_reads: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdCnt == 9));

  a_r5_read_in_image: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (busy && (int'(memY) < IMG_H)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(gradX) && $stable(gradY)));

endmodule

bind gradPrewittUnit gradChk #(
  .PIX_W  (PIX_W),
  .IMG_W  (IMG_W),
  .IMG_H  (IMG_H),
  .LATENCY(LATENCY)
) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .busy (busy),
  .done (done),
  .gradX(gradX),
  .gradY(gradY),
  .memRd(memRd),
  .memY (memY)
);

// File: tb/tb_gradPrewittUnit.sv
`timescale 1ns/1ps
module tb_gradPrewittUnit;

  localparam int NV = 17;
  // pattern, x, y, expected gradX, expected gradY
  // patterns: 0 = 2*x, 1 = 3*y, 2 = 255 for x>=10, 3 = 255 for y<5, 4 = 77, 5 = x+4*y
  localparam int VEC [NV][5] = '{
    '{0, 20, 20,   12,    0},
    '{0,  0,  7,    6,    0},
    '{0, 63, 30,    6,    0},
    '{1, 15, 10,    0,   18},
    '{1,  8,  0,    0,    9},
    '{1,  8, 47,    0,    9},
    '{2, 10,  3,  765,    0},
    '{2,  9,  3,  765,    0},
    '{2, 11,  3,    0,    0},
    '{2,  0,  0,    0,    0},
    '{2, 10,  0,  765,    0},
    '{3, 30,  5,    0, -765},
    '{3, 30,  4,    0, -765},
    '{4, 31, 17,    0,    0},
    '{5,  0,  0,    3,   12},
    '{5, 63, 47,    3,   12},
    '{5, 33, 22,    6,   24}
  };

  logic              clk = 0;
  logic              rstN = 0;
  logic              start = 0;
  logic [5:0]        pixX = 0;
  logic [5:0]        pixY = 0;
  logic              busy, done, memRd;
  logic signed [10:0] gradX, gradY;
  logic [5:0]        memX, memY;
  logic [7:0]        memData;

  int pattern = 0;
  int nChecks = 0;
  int nFail   = 0;
  int rdTotal = 0;
  int rdBad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gradPrewittUnit dut (
    .clk(clk), .rstN(rstN), .start(start), .pixX(pixX), .pixY(pixY),
    .busy(busy), .done(done), .gradX(gradX), .gradY(gradY),
    .memRd(memRd), .memX(memX), .memY(memY), .memData(memData)
  );

  function automatic logic [7:0] pixFn(int p, int x, int y);
    case (p)
      0: return 8'(2 * x);
      1: return 8'(3 * y);
      2: return (x >= 10) ? 8'd255 : 8'd0;
      3: return (y < 5) ? 8'd255 : 8'd0;
      4: return 8'd77;
      default: return 8'(x + 4 * y);
    endcase
  endfunction

  always @(posedge clk) begin
    if (memRd) begin
      memData <= pixFn(pattern, int'(memX), int'(memY));
      rdTotal <= rdTotal + 1;
      if (int'(memY) >= 48) rdBad <= rdBad + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input int x, input int y, input bit noise,
                       output int lat, output int gx, output int gy,
                       output int reads, output int busy1);
    int r0;
    @(negedge clk);
    start = 1; pixX = 6'(x); pixY = 6'(y);
    r0 = rdTotal;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    busy1 = int'(busy);
    lat = 0;
    while (!done && lat < 1000) begin
      if (noise && lat >= 4 && lat < 10) begin
        start = 1; pixX = 6'((x + 7) % 64); pixY = 6'((y + 3) % 48);
      end else begin
        start = 0;
      end
      @(negedge clk);
      lat++;
    end
    start = 0;
    gx = int'(gradX);
    gy = int'(gradY);
    reads = rdTotal - r0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int lat, gx, gy, reads, b1, hx, hy;
    repeat (4) @(negedge clk);
    // R1: during reset
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 memRd in reset", int'(memRd), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk("R1 gradX after reset", int'(gradX), 0);
    chk("R1 gradY after reset", int'(gradY), 0);
    chk("R1 busy after reset", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      pattern = VEC[i][0];
      runOp(VEC[i][1], VEC[i][2], 1'b0, lat, gx, gy, reads, b1);
      chk("R2 busy after accept", b1, 1);
      chk("R3 latency", lat, 33);
      chk("R6/R8/R10 gradX", gx, VEC[i][3]);
      chk("R7/R8/R10 gradY", gy, VEC[i][4]);
      chk("R5 read count", reads, 9);
      @(negedge clk);
      chk("R3 done single cycle", int'(done), 0);
      chk("R3 busy cleared after done", int'(busy), 0);
    end

    // R9: results held while idle
    hx = int'(gradX); hy = int'(gradY);
    repeat (6) @(negedge clk);
    chk("R9 gradX held", int'(gradX), hx);
    chk("R9 gradY held", int'(gradY), hy);

    // R4: requests while busy are ignored
    pattern = 5;
    runOp(33, 22, 1'b1, lat, gx, gy, reads, b1);
    chk("R4 latency unaffected", lat, 33);
    chk("R4 gradX unaffected", gx, 6);
    chk("R4 gradY unaffected", gy, 24);
    chk("R4 reads unaffected", reads, 9);
    @(negedge clk);
    repeat (3) begin
      chk("R4 no second operation", int'(busy), 0);
      @(negedge clk);
    end
    chk("R5 reads inside image", rdBad, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule